// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block follows the power-management state of a processor core. It watches three active-low request pins (stop-clock, sleep, deep-sleep), a halt-executed strobe, a vector of break events, a snoop request/serviced pair, a bus-clock tick and the response strobe of the Stop-Grant acknowledge bus cycle. It publishes the current state, a request to issue the acknowledge bus cycle and an enable that lets the clock tree stop.

The states and their codes on `state_o` are Normal = 0, Auto-Halt = 1, Stop-Grant = 2, Snoop = 3, Sleep = 4 and Deep-Sleep = 5. Stop-clock handling nests inside the halt state: a core that was halted when stop-clock arrived goes back to Auto-Halt when stop-clock is released. Stop-Grant is entered only after a fixed count of bus-clock ticks that follows the acknowledge response. All pins are plain level or strobe controls. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `lp_state_ctrl`

## Requirements
- R1: A low `rst_n` (asynchronous) or a high `core_reset_i` sampled on any clock edge, tick or not, puts the block in Normal (`state_o`=0) with `ack_req_o`=0 and `clk_stop_o`=0. `core_reset_i` overrides every other transition.
- R2: The three request pins are active low and pass through two synchroniser flops before use. The state, the handshake phase and the countdown change only on clock edges where `bus_tick_i` is high.
- R3: In Normal, with no stop-clock handshake pending, a high `halt_exec_i` moves the block to Auto-Halt (1).
- R4: In Auto-Halt, any bit of `brk_i` set moves the block to Normal and cancels a pending handshake. This has priority over stop-clock and snoop.
- R5: A stop-clock request seen in Normal or Auto-Halt raises `ack_req_o` on the next edge. It stays high until a tick edge with `ack_resp_i` high. `ack_req_o` is never high outside states 0 and 1.
- R6: Counting from the tick edge that takes the response, the block enters Stop-Grant (2) on the `STPG_DLY`-th (default 20) later tick edge. `clk_stop_o` is high exactly in states 2, 4 and 5.
- R7: If stop-clock is released while the request or the countdown is pending, the handshake is abandoned, `ack_req_o` falls and the state stays where it was.
- R8: Releasing stop-clock in Stop-Grant returns to Auto-Halt if the handshake began in Auto-Halt. Otherwise it returns to Normal. Stop-clock release has priority over sleep and snoop.
- R9: A high `snoop_req_i` in Auto-Halt (no handshake pending) or in Stop-Grant moves to Snoop (3). A high `snoop_done_i` there returns to the state the snoop came from.
- R10: An asserted sleep pin in Stop-Grant enters Sleep (4), and its release in Sleep returns to Stop-Grant. Elsewhere the sleep pin has no effect.
- R11: An asserted deep-sleep pin in Sleep enters Deep-Sleep (5), which is reachable only from Sleep. Its release returns to Sleep. Elsewhere the pin has no effect.
- R12: Snoop requests have no effect in Sleep and Deep-Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_reset_i | input | 1 | Core reset break event, forces Normal |
| stopclk_n_i | input | 1 | Stop-clock request, active low, asynchronous |
| sleep_n_i | input | 1 | Sleep request, active low, asynchronous |
| dpsleep_n_i | input | 1 | Deep-sleep request, active low, asynchronous |
| halt_exec_i | input | 1 | Halt instruction executed |
| brk_i | input | BRK_W | Break events (SMI, INIT, NMI, INTR, A20M, probe, interrupt message) |
| snoop_req_i | input | 1 | Bus snoop arrived |
| snoop_done_i | input | 1 | Bus snoop serviced |
| bus_tick_i | input | 1 | One-cycle bus-clock tick enable |
| ack_resp_i | input | 1 | Response phase of the acknowledge bus cycle |
| state_o | output | 3 | Current state code |
| ack_req_o | output | 1 | Request to issue the Stop-Grant acknowledge cycle |
| clk_stop_o | output | 1 | Clock may be stopped |

## Verification
A wrong internal state shows on `state_o` or `ack_req_o` at the first tick edge that makes a transition depend on it. A wrong return memory, for example, appears as the code after stop-clock release or after a serviced snoop, one tick after the releasing event. The countdown is internal, so an off-by-one can only be seen as Stop-Grant appearing one tick early or late. The bench therefore compares all three outputs against a behavioural model on every cycle, with ticks present on every cycle and with ticks only on every third cycle.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [2:0] {
    ST_NORM = 3'd0,
    ST_HALT = 3'd1,
    ST_SG   = 3'd2,
    ST_SNP  = 3'd3,
    ST_SLP  = 3'd4,
    ST_DSL  = 3'd5
  } lpc_state_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_WAIT = 2'd2
  } lpc_phase_e;
endpackage

// File: rtl/lpc_sync.sv
module lpc_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/lpc_gate_timer.sv
module lpc_gate_timer #(
  parameter int DLY = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic load_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] LOADV = CW'(DLY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (load_i)               cnt_q <= LOADV;
    else if (tick_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = tick_i && !clr_i && (cnt_q == CW'(1));

  // R6: the countdown never exceeds its load value
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOADV);
endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl
  import lpc_pkg::*;
#(
  parameter int BRK_W    = 7,
  parameter int STPG_DLY = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_reset_i,
  input  logic             stopclk_n_i,
  input  logic             sleep_n_i,
  input  logic             dpsleep_n_i,
  input  logic             halt_exec_i,
  input  logic [BRK_W-1:0] brk_i,
  input  logic             snoop_req_i,
  input  logic             snoop_done_i,
  input  logic             bus_tick_i,
  input  logic             ack_resp_i,
  output logic [2:0]       state_o,
  output logic             ack_req_o,
  output logic             clk_stop_o
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pin_s;
  logic stp, slp, dps, brk_any, tmr_exp, tmr_load, tmr_clr;
  lpc_state_e state_q, state_d;
  lpc_phase_e ph_q, ph_d;
  logic from_halt_q, from_halt_d, snp_sg_q, snp_sg_d;

  lpc_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({dpsleep_n_i, sleep_n_i, stopclk_n_i}),
    .q_o(pin_s)
  );

  assign stp     = ~pin_s[0];
  assign slp     = ~pin_s[1];
  assign dps     = ~pin_s[2];
  assign brk_any = |brk_i;

  lpc_gate_timer #(.DLY(STPG_DLY)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .load_i(tmr_load),
    .tick_i(bus_tick_i), .expire_o(tmr_exp)
  );

  always_comb begin
    state_d     = state_q;
    ph_d        = ph_q;
    from_halt_d = from_halt_q;
    snp_sg_d    = snp_sg_q;
    tmr_load    = 1'b0;
    tmr_clr     = 1'b0;
    if (core_reset_i) begin
      state_d = ST_NORM;
      ph_d    = PH_IDLE;
      tmr_clr = 1'b1;
    end else if (bus_tick_i) begin
      unique case (state_q)
        ST_NORM, ST_HALT: begin
          if (state_q == ST_HALT && brk_any) begin
            state_d = ST_NORM;
            ph_d    = PH_IDLE;
            tmr_clr = 1'b1;
          end else if (ph_q == PH_IDLE) begin
            if (stp) begin
              ph_d        = PH_REQ;
              from_halt_d = (state_q == ST_HALT);
            end else if (state_q == ST_NORM && halt_exec_i) begin
              state_d = ST_HALT;
            end else if (state_q == ST_HALT && snoop_req_i) begin
              state_d  = ST_SNP;
              snp_sg_d = 1'b0;
            end
          end else if (!stp) begin
            ph_d    = PH_IDLE;
            tmr_clr = 1'b1;
          end else if (ph_q == PH_REQ) begin
            if (ack_resp_i) begin
              ph_d     = PH_WAIT;
              tmr_load = 1'b1;
            end
          end else if (tmr_exp) begin
            state_d = ST_SG;
            ph_d    = PH_IDLE;
          end
        end
        ST_SG: begin
          if (!stp)             state_d = from_halt_q ? ST_HALT : ST_NORM;
          else if (slp)         state_d = ST_SLP;
          else if (snoop_req_i) begin
            state_d  = ST_SNP;
            snp_sg_d = 1'b1;
          end
        end
        ST_SNP: if (snoop_done_i) state_d = snp_sg_q ? ST_SG : ST_HALT;
        ST_SLP: begin
          if (dps)       state_d = ST_DSL;
          else if (!slp) state_d = ST_SG;
        end
        ST_DSL: if (!dps) state_d = ST_SLP;
        default: state_d = ST_NORM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_NORM;
      ph_q        <= PH_IDLE;
      from_halt_q <= 1'b0;
      snp_sg_q    <= 1'b0;
    end else begin
      state_q     <= state_d;
      ph_q        <= ph_d;
      from_halt_q <= from_halt_d;
      snp_sg_q    <= snp_sg_d;
    end
  end

  assign state_o    = state_q;
  assign ack_req_o  = (ph_q == PH_REQ);
  assign clk_stop_o = (state_q == ST_SG) || (state_q == ST_SLP) || (state_q == ST_DSL);

  // R1: core reset lands in Normal with no request outstanding
  p_reset_normal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset_i |=> (state_q == ST_NORM) && !ack_req_o);

  // R2: without a tick nothing moves
  p_no_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_tick_i && !core_reset_i) |=> $stable(state_q) && $stable(ph_q));

  // R5: the acknowledge request exists only in Normal or Auto-Halt
  p_ackreq_scope_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o |-> (state_q == ST_NORM || state_q == ST_HALT));

  // R6: entry into Stop-Grant from Normal/Auto-Halt only on countdown expiry
  p_sg_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WAIT && !core_reset_i && bus_tick_i && stp && !tmr_exp)
      |=> state_q != ST_SG);

  // R11: Deep-Sleep is reachable only through Sleep
  p_dsl_path_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_SLP && state_q != ST_DSL) |=> state_q != ST_DSL);
endmodule

// File: tb/tb_lp_state_ctrl.sv
module tb_lp_state_ctrl;
  localparam int BRK_W = 7;
  localparam int DLY   = 20;

  logic clk = 1'b0, rst_n = 1'b0, core_reset_i = 1'b0;
  logic stopclk_n_i = 1'b1, sleep_n_i = 1'b1, dpsleep_n_i = 1'b1;
  logic halt_exec_i = 1'b0, snoop_req_i = 1'b0, snoop_done_i = 1'b0;
  logic bus_tick_i = 1'b0, ack_resp_i = 1'b0;
  logic [BRK_W-1:0] brk_i = '0;
  logic [2:0] state_o;
  logic ack_req_o, clk_stop_o;

  int tests = 0, fails = 0, cyc_n = 0;
  int tick_every = 1;
  bit tick_en = 1'b1;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  lp_state_ctrl #(.BRK_W(BRK_W), .STPG_DLY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .core_reset_i(core_reset_i),
    .stopclk_n_i(stopclk_n_i), .sleep_n_i(sleep_n_i), .dpsleep_n_i(dpsleep_n_i),
    .halt_exec_i(halt_exec_i), .brk_i(brk_i), .snoop_req_i(snoop_req_i),
    .snoop_done_i(snoop_done_i), .bus_tick_i(bus_tick_i), .ack_resp_i(ack_resp_i),
    .state_o(state_o), .ack_req_o(ack_req_o), .clk_stop_o(clk_stop_o)
  );

  always @(posedge clk) begin
    #1;
    cyc_n++;
    bus_tick_i = tick_en && (cyc_n % tick_every == 0);
  end

  // behavioural reference: state number, handshake phase, ticks left
  int m_st, m_ph, m_left;
  bit m_fh, m_fsg;
  logic [2:0] m_p1, m_p2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ph = 0; m_left = 0; m_fh = 0; m_fsg = 0;
      m_p1 = 3'b111; m_p2 = 3'b111;
    end else begin
      bit stp, slp, dps;
      stp = !m_p2[0]; slp = !m_p2[1]; dps = !m_p2[2];
      m_p2 = m_p1;
      m_p1 = {dpsleep_n_i, sleep_n_i, stopclk_n_i};
      if (core_reset_i) begin
        m_st = 0; m_ph = 0; m_left = 0;
      end else if (bus_tick_i) begin
        if (m_st <= 1) begin
          if (m_st == 1 && brk_i != 0) begin m_st = 0; m_ph = 0; m_left = 0; end
          else if (m_ph == 0) begin
            if (stp) begin m_ph = 1; m_fh = (m_st == 1); end
            else if (m_st == 0 && halt_exec_i) m_st = 1;
            else if (m_st == 1 && snoop_req_i) begin m_st = 3; m_fsg = 0; end
          end
          else if (!stp) begin m_ph = 0; m_left = 0; end
          else if (m_ph == 1) begin if (ack_resp_i) begin m_ph = 2; m_left = DLY; end end
          else begin
            m_left--;
            if (m_left == 0) begin m_st = 2; m_ph = 0; end
          end
        end else if (m_st == 2) begin
          if (!stp) m_st = m_fh ? 1 : 0;
          else if (slp) m_st = 4;
          else if (snoop_req_i) begin m_st = 3; m_fsg = 1; end
        end else if (m_st == 3) begin
          if (snoop_done_i) m_st = m_fsg ? 2 : 1;
        end else if (m_st == 4) begin
          if (dps) m_st = 5; else if (!slp) m_st = 2;
        end else begin
          if (!dps) m_st = 4;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_stop;
      exp_stop = (m_st == 2 || m_st == 4 || m_st == 5);
      tests++;
      if (int'(state_o) != m_st || ack_req_o != (m_ph == 1) || clk_stop_o != exp_stop) begin
        fails++;
        $display("FAIL %s model compare: state=%0d ack=%0b stop=%0b expected state=%0d ack=%0b stop=%0b",
                 cur_req, state_o, ack_req_o, clk_stop_o, m_st, (m_ph == 1), exp_stop);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      if (cyc_n > 150000) begin
        fails++;
        $display("FAIL watchdog: cycles=%0d expected below 150000", cyc_n);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1.5;
  endtask

  task automatic settle();
    cyc(4 * tick_every + 4);
  endtask

  task automatic check(int exp_st, bit exp_ack, string req);
    @(negedge clk);
    tests++;
    if (int'(state_o) != exp_st || ack_req_o != exp_ack) begin
      fails++;
      $display("FAIL %s directed: state=%0d ack=%0b expected state=%0d ack=%0b",
               req, state_o, ack_req_o, exp_st, exp_ack);
    end
    cyc(1);
  endtask

  task automatic pulse_halt();  halt_exec_i = 1; cyc(tick_every); halt_exec_i = 0; settle(); endtask
  task automatic pulse_snoop(); snoop_req_i = 1; cyc(tick_every); snoop_req_i = 0; settle(); endtask
  task automatic pulse_done();  snoop_done_i = 1; cyc(tick_every); snoop_done_i = 0; settle(); endtask
  task automatic pulse_ack();   ack_resp_i = 1; cyc(tick_every); ack_resp_i = 0; endtask

  task automatic enter_sg(int from_st);
    cur_req = "R5";
    stopclk_n_i = 0; settle();
    check(from_st, 1'b1, "R5");
    pulse_ack();
    cur_req = "R6";
    cyc(tick_every * (DLY - 3));
    check(from_st, 1'b0, "R6");
    cyc(tick_every * 4 + 2);
    check(2, 1'b0, "R6");
  endtask

  task automatic run_suite();
    cur_req = "R3"; pulse_halt(); check(1, 1'b0, "R3");
    cur_req = "R9"; pulse_snoop(); check(3, 1'b0, "R9");
    pulse_done(); check(1, 1'b0, "R9");
    for (int b = 0; b < BRK_W; b++) begin
      cur_req = "R4";
      if (b > 0) pulse_halt();
      brk_i = BRK_W'(1) << b; cyc(tick_every); brk_i = '0; settle();
      check(0, 1'b0, "R4");
    end
    cur_req = "R10"; sleep_n_i = 0; settle(); check(0, 1'b0, "R10");
    sleep_n_i = 1; settle();
    enter_sg(0);
    cur_req = "R8"; stopclk_n_i = 1; settle(); check(0, 1'b0, "R8");
    pulse_halt();
    enter_sg(1);
    cur_req = "R11"; dpsleep_n_i = 0; settle(); check(2, 1'b0, "R11");
    dpsleep_n_i = 1; settle();
    cur_req = "R9"; pulse_snoop(); check(3, 1'b0, "R9");
    pulse_done(); check(2, 1'b0, "R9");
    cur_req = "R10"; sleep_n_i = 0; settle(); check(4, 1'b0, "R10");
    cur_req = "R11"; dpsleep_n_i = 0; settle(); check(5, 1'b0, "R11");
    cur_req = "R12"; pulse_snoop(); check(5, 1'b0, "R12");
    cur_req = "R11"; dpsleep_n_i = 1; settle(); check(4, 1'b0, "R11");
    cur_req = "R12"; pulse_snoop(); check(4, 1'b0, "R12");
    cur_req = "R10"; sleep_n_i = 1; settle(); check(2, 1'b0, "R10");
    cur_req = "R8"; stopclk_n_i = 1; settle(); check(1, 1'b0, "R8");
    cur_req = "R7"; stopclk_n_i = 0; settle(); check(1, 1'b1, "R7");
    stopclk_n_i = 1; settle(); check(1, 1'b0, "R7");
    brk_i = 1; cyc(tick_every); brk_i = '0; settle();
    stopclk_n_i = 0; settle(); pulse_ack(); cyc(tick_every * (DLY / 2));
    stopclk_n_i = 1; settle(); check(0, 1'b0, "R7");
    cyc(tick_every * DLY); check(0, 1'b0, "R7");
    cur_req = "R1"; pulse_halt(); enter_sg(1);
    cur_req = "R1"; sleep_n_i = 0; settle();
    core_reset_i = 1; cyc(1); core_reset_i = 0;
    check(0, 1'b0, "R1");
    sleep_n_i = 1; stopclk_n_i = 1; settle();
  endtask

  initial begin
    cyc(3);
    rst_n = 1; cyc(1);
    check(0, 1'b0, "R1");
    tests++;
    if (clk_stop_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset clk_stop: %0b expected 0", clk_stop_o);
    end
    run_suite();
    tick_every = 3;
    settle();
    run_suite();
    cur_req = "R2"; tick_en = 0; cyc(2);
    halt_exec_i = 1; cyc(10); halt_exec_i = 0; cyc(2);
    check(0, 1'b0, "R2");
    stopclk_n_i = 0; cyc(10); check(0, 1'b0, "R2");
    stopclk_n_i = 1; cyc(4);
    tick_en = 1; tick_every = 1; settle(); check(0, 1'b0, "R2");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule